// File: doc/BRIEF.md
# Palette Data Width Formatter

This block sits between a color palette memory and its two consumers: the DAC output path and the host read-back path. The palette always stores full 8-bit entries. When the block runs in the narrow 6-bit compatibility mode, it rewrites each value differently on each path. On the DAC path the six meaningful bits move up to the top of the byte, and the two bottom bits become zero. On the read-back path the two top bits are cleared. In 8-bit mode both paths pass values through unchanged. Both formatting paths are combinational.

A strap pin selects the width: high means 8-bit, low means 6-bit. Software can take over from the pin through a small override register, which holds an enable bit and a width value bit. Host writes arrive on an 8-bit bus with an active-low write strobe. The strobe, the address select and the data are brought into the core clock domain through synchronizer stages. A small state machine then detects the strobe's rising edge. It commits the captured byte either to the palette write port (as a one-cycle pulse) or to the override register.

State machine `pal_wr_fsm` has three states:
- WS_IDLE waits with the strobe high. It moves to WS_ARMED when the synchronized strobe goes low.
- WS_ARMED holds while the strobe stays low. It moves to WS_COMMIT, capturing address and data, when the strobe returns high.
- WS_COMMIT lasts one cycle and issues the commit. It returns to WS_IDLE, or goes straight to WS_ARMED if a new low strobe is already visible.

Top module: `pal_width_fmt`

## Requirements
- R1: In 8-bit mode (`mode_8bit`=1), `dac_out` equals `dac_in` and `rb_out` equals `rb_in`. Bit 7 is the MSB.
- R2: In 6-bit mode, `dac_out` = {`dac_in`[5:0], 2'b00}.
- R3: In 6-bit mode, `rb_out` = {2'b00, `rb_in`[5:0]}.
- R4: With the override disabled, `mode_8bit` follows `width_pin` (high = 8-bit). A change on the pin reaches `mode_8bit` after exactly 2 clock edges.
- R5: A host write with `host_addr`=1 loads the override register. Data bit 0 is the enable and data bit 1 is the width value (1 = 8-bit). While the enable is set, the value bit sets `mode_8bit` and the pin has no effect.
- R6: After reset the override is disabled, `pal_wr_stb` is low, and `mode_8bit` is 0. With the pin tied low, the block therefore stays in 6-bit mode.
- R7: A host write with `host_addr`=0 produces one `pal_wr_stb` pulse. During that pulse, `pal_wr_data` equals the bus value present at the strobe's rising edge. Later changes on the bus have no effect.
- R8: Each low-then-high cycle of `host_wr_n` yields exactly one commit. A strobe held low yields none. `pal_wr_stb` is never high for two cycles in a row.
- R9: An override write produces no `pal_wr_stb` pulse, and a palette write leaves `mode_8bit` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_pin | input | 1 | Width strap, high selects 8-bit |
| host_wr_n | input | 1 | Active-low host write strobe |
| host_addr | input | 1 | Write target: 0 palette, 1 override register |
| host_data | input | 8 | Host write data |
| pal_wr_stb | output | 1 | One-cycle palette write pulse |
| pal_wr_data | output | 8 | Captured palette write byte |
| dac_in | input | 8 | Palette entry toward the DAC |
| dac_out | output | 8 | Formatted DAC value |
| rb_in | input | 8 | Palette entry being read back |
| rb_out | output | 8 | Formatted read-back value |
| mode_8bit | output | 1 | Active width, 1 = 8-bit |

## Verification
A wrong mode state shows up immediately, and on both paths: `dac_out` would carry nonzero low bits, or `rb_out` would carry nonzero high bits, in the same cycle as the bad mode. A state machine that skips WS_ARMED or stays in WS_COMMIT shows at the pulse counter within four cycles of the strobe edge, either as a missing pulse or a doubled one. Corrupted capture timing shows as a pulse carrying the post-edge garbage byte instead of the byte present at the edge.

// File: rtl/pal_fmt_pkg.sv
package pal_fmt_pkg;
    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_ARMED  = 2'd1,
        WS_COMMIT = 2'd2
    } ws_state_e;

    // Override register layout: bit 0 enable, bit 1 width value.
    typedef struct packed {
        logic wide;
        logic en;
    } ovr_reg_t;

    localparam int OVR_W = $bits(ovr_reg_t);
endpackage

// File: rtl/pal_sync.sv
module pal_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= {W{RST_VAL}};
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= {W{RST_VAL}};
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pal_wr_fsm.sv
module pal_wr_fsm
    import pal_fmt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n_s,
    input  logic          addr_s,
    input  logic [DW-1:0] data_s,
    output logic          commit_pal,
    output logic          commit_ovr,
    output logic [DW-1:0] wdata
);
    ws_state_e state, nxt;
    logic          addr_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WS_IDLE:   if (!wr_n_s) nxt = WS_ARMED;
            WS_ARMED:  if (wr_n_s)  nxt = WS_COMMIT;
            WS_COMMIT: nxt = wr_n_s ? WS_IDLE : WS_ARMED;
            default:   nxt = WS_IDLE;
        endcase
    end

    // Capture on the transition that marks the strobe's rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= 1'b0;
            data_q <= '0;
        end else if (state == WS_ARMED && wr_n_s) begin
            addr_q <= addr_s;
            data_q <= data_s;
        end
    end

    always_comb begin
        commit_pal = 1'b0;
        commit_ovr = 1'b0;
        unique case (state)
            WS_COMMIT: begin
                commit_pal = !addr_q;
                commit_ovr = addr_q;
            end
            default: ;
        endcase
    end

    assign wdata = data_q;
endmodule

// File: rtl/pal_mode_ctl.sv
module pal_mode_ctl
    import pal_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_s,
    input  logic             ovr_we,
    input  logic [OVR_W-1:0] ovr_wdata,
    output logic             wide
);
    ovr_reg_t ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ovr_q <= '0;
        else if (ovr_we) ovr_q <= ovr_reg_t'(ovr_wdata);
    end

    assign wide = ovr_q.en ? ovr_q.wide : pin_s;
endmodule

// File: rtl/pal_fmt_path.sv
module pal_fmt_path #(
    parameter int DW       = 8,
    parameter int NW       = 6,
    parameter bit SHIFT_UP = 1'b1
) (
    input  logic          wide,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int PAD = DW - NW;
    logic [DW-1:0] narrow;

    generate
        if (SHIFT_UP) begin : g_up
            assign narrow = {din[NW-1:0], {PAD{1'b0}}};
        end else begin : g_clr
            assign narrow = {{PAD{1'b0}}, din[NW-1:0]};
        end
    endgenerate

    assign dout = wide ? din : narrow;
endmodule

// File: rtl/pal_width_fmt.sv
module pal_width_fmt
    import pal_fmt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int NARROW_W    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              width_pin,
    input  logic              host_wr_n,
    input  logic              host_addr,
    input  logic [DATA_W-1:0] host_data,
    output logic              pal_wr_stb,
    output logic [DATA_W-1:0] pal_wr_data,
    input  logic [DATA_W-1:0] dac_in,
    output logic [DATA_W-1:0] dac_out,
    input  logic [DATA_W-1:0] rb_in,
    output logic [DATA_W-1:0] rb_out,
    output logic              mode_8bit
);
    localparam int BUS_W = DATA_W + 1;

    logic              wr_n_s, pin_s, addr_s, ovr_we;
    logic [DATA_W-1:0] data_s, wdata;

    pal_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strobe_sync (
        .clk(clk), .rst_n(rst_n), .d(host_wr_n), .q(wr_n_s));

    pal_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(width_pin), .q(pin_s));

    pal_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({host_addr, host_data}), .q({addr_s, data_s}));

    pal_wr_fsm #(.DW(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_n_s(wr_n_s), .addr_s(addr_s),
        .data_s(data_s), .commit_pal(pal_wr_stb), .commit_ovr(ovr_we),
        .wdata(wdata));

    pal_mode_ctl u_mode (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .ovr_we(ovr_we),
        .ovr_wdata(wdata[OVR_W-1:0]), .wide(mode_8bit));

    pal_fmt_path #(.DW(DATA_W), .NW(NARROW_W), .SHIFT_UP(1'b1)) u_dac_path (
        .wide(mode_8bit), .din(dac_in), .dout(dac_out));

    pal_fmt_path #(.DW(DATA_W), .NW(NARROW_W), .SHIFT_UP(1'b0)) u_rb_path (
        .wide(mode_8bit), .din(rb_in), .dout(rb_out));

    assign pal_wr_data = wdata;
endmodule

// File: rtl/pal_width_fmt_chk.sv
module pal_width_fmt_chk #(
    parameter int DATA_W   = 8,
    parameter int NARROW_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_8bit,
    input logic              pal_wr_stb,
    input logic [DATA_W-1:0] dac_in,
    input logic [DATA_W-1:0] dac_out,
    input logic [DATA_W-1:0] rb_in,
    input logic [DATA_W-1:0] rb_out
);
    localparam int PAD = DATA_W - NARROW_W;

    // R1
    wide_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_8bit |-> (dac_out == dac_in) && (rb_out == rb_in));

    // R2
    dac_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_8bit |-> (dac_out[PAD-1:0] == '0) && (dac_out[DATA_W-1:PAD] == dac_in[NARROW_W-1:0]));

    // R3
    rb_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_8bit |-> (rb_out[DATA_W-1:NARROW_W] == '0) && (rb_out[NARROW_W-1:0] == rb_in[NARROW_W-1:0]));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_wr_stb |=> !pal_wr_stb);
endmodule

bind pal_width_fmt pal_width_fmt_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_8bit(mode_8bit), .pal_wr_stb(pal_wr_stb),
    .dac_in(dac_in), .dac_out(dac_out), .rb_in(rb_in), .rb_out(rb_out));

// File: tb/pal_width_fmt_test.sv
`timescale 1ns/1ps
module pal_width_fmt_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       width_pin = 1'b0;
    logic       host_wr_n = 1'b1;
    logic       host_addr = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       pal_wr_stb;
    logic [7:0] pal_wr_data;
    logic [7:0] dac_in = 8'h00;
    logic [7:0] dac_out;
    logic [7:0] rb_in = 8'h00;
    logic [7:0] rb_out;
    logic       mode_8bit;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    int double_hi = 0;
    logic [7:0] last_wdata = 8'h00;
    logic       prev_stb = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    pal_width_fmt uut (
        .clk(clk), .rst_n(rst_n), .width_pin(width_pin), .host_wr_n(host_wr_n),
        .host_addr(host_addr), .host_data(host_data), .pal_wr_stb(pal_wr_stb),
        .pal_wr_data(pal_wr_data), .dac_in(dac_in), .dac_out(dac_out),
        .rb_in(rb_in), .rb_out(rb_out), .mode_8bit(mode_8bit));

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (pal_wr_stb) begin
            pulses = pulses + 1;
            last_wdata = pal_wr_data;
            if (prev_stb) double_hi = double_hi + 1;
        end
        prev_stb = pal_wr_stb;
    end

    function automatic logic [7:0] exp_dac(input logic wide, input logic [7:0] d);
        return wide ? d : {d[5:0], 2'b00};
    endfunction

    function automatic logic [7:0] exp_rb(input logic wide, input logic [7:0] d);
        return wide ? d : {2'b00, d[5:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        host_data = d;
        host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        host_data = $urandom();
        host_addr = $urandom();
        repeat (2) @(negedge clk);
    endtask

    task automatic check_paths(input string req, input logic wide, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dac_in = $urandom();
            rb_in = $urandom();
            #1;
            check({req, " dac"}, dac_out, exp_dac(wide, dac_in));
            check({req, " rb"}, rb_out, exp_rb(wide, rb_in));
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        check("R6 mode", mode_8bit, 1'b0);
        check("R6 stb", pal_wr_stb, 1'b0);
        check("R6 pulses", pulses, 0);
        check_paths("R2/R3 after reset", 1'b0, 8);

        // R4 pin timing: two edges
        width_pin = 1'b1;
        @(negedge clk);
        check("R4 one edge", mode_8bit, 1'b0);
        @(negedge clk);
        check("R4 two edges", mode_8bit, 1'b1);
        check_paths("R1", 1'b1, 24);
        dac_in = 8'hFF; rb_in = 8'hFF; #1;
        check("R1 ones dac", dac_out, 8'hFF);

        width_pin = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 back low", mode_8bit, 1'b0);
        check_paths("R2/R3", 1'b0, 24);
        dac_in = 8'hFF; rb_in = 8'hFF; #1;
        check("R2 ones", dac_out, 8'hFC);
        check("R3 ones", rb_out, 8'h3F);

        // R7 palette write, R9 mode unchanged
        p0 = pulses;
        host_write(1'b0, 8'hA5);
        check("R7 count", pulses, p0 + 1);
        check("R7 data", last_wdata, 8'hA5);
        check("R9 mode kept", mode_8bit, 1'b0);

        // R5 override forces 6-bit with pin high, R9 no pulse
        width_pin = 1'b1;
        p0 = pulses;
        host_write(1'b1, 8'h01);
        check("R5 forced narrow", mode_8bit, 1'b0);
        check("R9 no pulse", pulses, p0);
        width_pin = 1'b0;
        repeat (4) @(negedge clk);
        host_write(1'b1, 8'h03);
        check("R5 forced wide", mode_8bit, 1'b1);
        check_paths("R1 forced", 1'b1, 8);
        host_write(1'b1, 8'h00);
        check("R5 released", mode_8bit, 1'b0);

        // R8 strobe held low
        p0 = pulses;
        @(negedge clk);
        host_addr = 1'b0; host_data = 8'h3C; host_wr_n = 1'b0;
        repeat (20) @(negedge clk);
        check("R8 held low", pulses, p0);
        host_wr_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R8 one commit", pulses, p0 + 1);
        check("R7 held data", last_wdata, 8'h3C);

        // Random palette writes
        for (int k = 0; k < 20; k++) begin
            logic [7:0] d;
            d = $urandom();
            p0 = pulses;
            host_write(1'b0, d);
            check("R7 rand count", pulses, p0 + 1);
            check("R7 rand data", last_wdata, d);
        end
        check("R8 no double", double_hi, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule